// File: doc/BRIEF.md
# DMA Status Counter and Interrupt Unit

This block keeps the status of a MAC's transmit and receive DMA engines and turns it into one interrupt line. Each engine sends it single-cycle event pulses: the transmit side reports a finished packet or an underrun, and the receive side reports a stored packet or an overflow. Each direction has an 8-bit packet counter and sticky flags. An interrupt mask selects which pending bits may raise the interrupt.

Software reaches the block through a 32-bit register port addressed by word offset. Reads are combinational from the registers. Software acknowledges status by writing 1s. A 1 written to an error flag clears that flag. A 1 written to a packet flag takes one packet off the counter. The packet flag stays set until the counter has drained to zero, so several packets can be serviced one at a time.

Top module: `dma_status_irq`

## Requirements
- R1: The transmit status word sits at word offset 0x62 (byte 0x188). It holds the sent-packet counter in bits [23:16], the underrun flag in bit 1 and the packet-sent flag in bit 0. Every other bit reads 0.
- R2: The receive status word sits at word offset 0x65 (byte 0x194). It holds the received-packet counter in bits [23:16], the overflow flag in bit 2 and the packet-received flag in bit 0. Every other bit reads 0.
- R3: A sent or received event pulse adds one to the counter of its direction and sets that direction's packet flag.
- R4: A counter holds at 255 when further events arrive.
- R5: Writing 1 to bit 0 of a status word subtracts one from its counter, and the counter never goes below 0. The packet flag clears only when the resulting count is 0. Writing 0 to bit 0 changes nothing.
- R6: An underrun or overflow pulse sets its flag, and writing 1 to the flag's bit clears it. When a pulse and a clearing write fall in the same cycle, the flag ends up set.
- R7: When a packet event and a packet acknowledge fall in the same cycle, the counter keeps its value and the packet flag is 1.
- R8: The mask word at word offset 0x66 (byte 0x198) is a full 32-bit read/write register. The interrupt word at word offset 0x67 is read-only and equals mask[7:0] AND a pending vector, with all upper bits reading 0. The pending vector places receive status bits [3:0] in bits [7:4] and transmit status bits [3:0] in bits [3:0]. Writes to the interrupt word have no effect.
- R9: The interrupt output is 1 exactly when the interrupt word is nonzero.
- R10: Reset clears both status words and the mask, and holds the interrupt output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 7 | Word offset for the register access |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| txSentEvt | input | 1 | Transmit engine finished a packet |
| txUnderrunEvt | input | 1 | Transmit engine ran out of data |
| rxRecvEvt | input | 1 | Receive engine stored a packet |
| rxOverflowEvt | input | 1 | Receive engine had no free buffer |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench drains a counter one acknowledge at a time and checks two things: the packet flag stays set while packets remain, and one more acknowledge at zero neither wraps the counter to 255 nor leaves the flag behind. It drives 260 events to reach saturation and expects the counter to stay at 255 rather than roll over to a small value. It places events and acknowledges in the same cycle. A design with the wrong priority would show a lost count, a stray decrement or a cleared error flag. It opens the mask one nibble at a time and writes into the interrupt word. A swapped nibble packing or a writable interrupt word would show up as a wrong interrupt line or wrong read data.

// File: rtl/dsi_pkg.sv
package dsi_pkg;

  localparam int PKT_BIT    = 0;
  localparam int TX_ERR_BIT = 1;
  localparam int RX_ERR_BIT = 2;
  localparam int CNT_LSB    = 16;
  localparam int NIB_W      = 4;
  localparam int NUM_CH     = 2;

  typedef struct packed {
    logic txPktAck;
    logic txErrAck;
    logic rxPktAck;
    logic rxErrAck;
    logic maskWr;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TX,
    SEL_RX,
    SEL_MASK,
    SEL_INTR
  } rdSel_t;

endpackage

// File: rtl/dsi_ctrl.sv
module dsi_ctrl
  import dsi_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int TX_OFF   = 'h62,
  parameter int RX_OFF   = 'h65,
  parameter int MASK_OFF = 'h66,
  parameter int INTR_OFF = 'h67
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output ctlStrobes_t       strobes,
  output rdSel_t            rdSel
);

  localparam logic [ADDR_W-1:0] TX_A   = ADDR_W'(TX_OFF);
  localparam logic [ADDR_W-1:0] RX_A   = ADDR_W'(RX_OFF);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFF);
  localparam logic [ADDR_W-1:0] INTR_A = ADDR_W'(INTR_OFF);

  logic hitTx, hitRx, hitMask, hitIntr;

  always_comb begin
    hitTx   = (regAddr == TX_A);
    hitRx   = (regAddr == RX_A);
    hitMask = (regAddr == MASK_A);
    hitIntr = (regAddr == INTR_A);
  end

  always_comb begin
    strobes.txPktAck = regWrEn && hitTx && regWrData[PKT_BIT];
    strobes.txErrAck = regWrEn && hitTx && regWrData[TX_ERR_BIT];
    strobes.rxPktAck = regWrEn && hitRx && regWrData[PKT_BIT];
    strobes.rxErrAck = regWrEn && hitRx && regWrData[RX_ERR_BIT];
    strobes.maskWr   = regWrEn && hitMask;
  end

  always_comb begin
    if (hitTx)        rdSel = SEL_TX;
    else if (hitRx)   rdSel = SEL_RX;
    else if (hitMask) rdSel = SEL_MASK;
    else if (hitIntr) rdSel = SEL_INTR;
    else              rdSel = SEL_NONE;
  end

endmodule

// File: rtl/dsi_pkt_track.sv
module dsi_pkt_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtInc,
  input  logic             ackDec,
  input  logic             evtErr,
  input  logic             ackErr,
  output logic [CNT_W-1:0] cnt,
  output logic             pktFlag,
  output logic             errFlag
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      pktFlag <= 1'b0;
    end else begin
      unique case ({evtInc, ackDec})
        2'b10: begin
          if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
          pktFlag <= 1'b1;
        end
        2'b01: begin
          if (cnt != '0) cnt <= cnt - CNT_ONE;
          if (cnt <= CNT_ONE) pktFlag <= 1'b0;
        end
        2'b11: pktFlag <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       errFlag <= 1'b0;
    else if (evtErr) errFlag <= 1'b1;
    else if (ackErr) errFlag <= 1'b0;
  end

endmodule

// File: rtl/dsi_datapath.sv
module dsi_datapath
  import dsi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txSentEvt,
  input  logic              txUnderrunEvt,
  input  logic              rxRecvEvt,
  input  logic              rxOverflowEvt,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam int VEC_W = NUM_CH * NIB_W;

  logic [NUM_CH-1:0] incEvt, incAck, errEvt, errAck;
  logic [CNT_W-1:0]  chCnt   [NUM_CH];
  logic [NUM_CH-1:0] chPkt, chErr;
  logic [DATA_W-1:0] statusWord [NUM_CH];
  logic [DATA_W-1:0] maskReg;
  logic [VEC_W-1:0]  pendVec, intrVec;

  always_comb begin
    incEvt = {rxRecvEvt, txSentEvt};
    incAck = {strobes.rxPktAck, strobes.txPktAck};
    errEvt = {rxOverflowEvt, txUnderrunEvt};
    errAck = {strobes.rxErrAck, strobes.txErrAck};
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int ERR_POS = (ch == 0) ? TX_ERR_BIT : RX_ERR_BIT;

    dsi_pkt_track #(.CNT_W(CNT_W)) i_track (
      .clk    (clk),
      .rstN   (rstN),
      .evtInc (incEvt[ch]),
      .ackDec (incAck[ch]),
      .evtErr (errEvt[ch]),
      .ackErr (errAck[ch]),
      .cnt    (chCnt[ch]),
      .pktFlag(chPkt[ch]),
      .errFlag(chErr[ch])
    );

    always_comb begin
      statusWord[ch]                  = '0;
      statusWord[ch][CNT_LSB +: CNT_W] = chCnt[ch];
      statusWord[ch][PKT_BIT]         = chPkt[ch];
      statusWord[ch][ERR_POS]         = chErr[ch];
    end

    assign pendVec[ch*NIB_W +: NIB_W] = statusWord[ch][NIB_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskReg <= '0;
    else if (strobes.maskWr) maskReg <= wrData;
  end

  always_comb begin
    intrVec = maskReg[VEC_W-1:0] & pendVec;
    irqOut  = |intrVec;
  end

  always_comb begin
    unique case (rdSel)
      SEL_TX:   rdData = statusWord[0];
      SEL_RX:   rdData = statusWord[1];
      SEL_MASK: rdData = maskReg;
      SEL_INTR: rdData = DATA_W'(intrVec);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_status_irq.sv
module dma_status_irq
  import dsi_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 8,
  parameter int TX_OFF   = 'h62,
  parameter int RX_OFF   = 'h65,
  parameter int MASK_OFF = 'h66,
  parameter int INTR_OFF = 'h67
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txSentEvt,
  input  logic              txUnderrunEvt,
  input  logic              rxRecvEvt,
  input  logic              rxOverflowEvt,
  output logic              irqOut
);

  ctlStrobes_t strobes;
  rdSel_t      rdSel;

  dsi_ctrl #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .TX_OFF  (TX_OFF),
    .RX_OFF  (RX_OFF),
    .MASK_OFF(MASK_OFF),
    .INTR_OFF(INTR_OFF)
  ) i_ctrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strobes  (strobes),
    .rdSel    (rdSel)
  );

  dsi_datapath #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .rdSel        (rdSel),
    .wrData       (regWrData),
    .txSentEvt    (txSentEvt),
    .txUnderrunEvt(txUnderrunEvt),
    .rxRecvEvt    (rxRecvEvt),
    .rxOverflowEvt(rxOverflowEvt),
    .rdData       (regRdData),
    .irqOut       (irqOut)
  );

endmodule

// File: rtl/dsi_checker.sv
module dsi_checker #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int TX_OFF   = 'h62,
  parameter int RX_OFF   = 'h65,
  parameter int INTR_OFF = 'h67
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regRdData,
  input logic              txSentEvt,
  input logic              txUnderrunEvt,
  input logic              rxOverflowEvt,
  input logic              irqOut
);

  localparam logic [ADDR_W-1:0] TX_A   = ADDR_W'(TX_OFF);
  localparam logic [ADDR_W-1:0] RX_A   = ADDR_W'(RX_OFF);
  localparam logic [ADDR_W-1:0] INTR_A = ADDR_W'(INTR_OFF);

  AST_TX_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == TX_A) |-> (regRdData[31:24] == '0 && regRdData[15:2] == '0)); // R1

  AST_RX_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == RX_A) |-> (regRdData[31:24] == '0 && regRdData[15:3] == '0 && !regRdData[1])); // R2

  AST_SENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    txSentEvt |=> (regAddr != TX_A || regRdData[0])); // R3

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == TX_A && $past(regAddr == TX_A) && $past(regRdData[23:16] == 8'hFF)
      && $past(txSentEvt) && !$past(regWrEn)) |-> (regRdData[23:16] == 8'hFF)); // R4

  AST_UNDERRUN_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrunEvt |=> (regAddr != TX_A || regRdData[1])); // R6

  AST_OVERFLOW_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflowEvt |=> (regAddr != RX_A || regRdData[2])); // R6

  AST_IRQ_MIRRORS_INTR: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == INTR_A) |-> (irqOut == (regRdData != '0))); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> !irqOut); // R10

endmodule

bind dma_status_irq dsi_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .TX_OFF  (TX_OFF),
  .RX_OFF  (RX_OFF),
  .INTR_OFF(INTR_OFF)
) i_dsi_checker (
  .clk          (clk),
  .rstN         (rstN),
  .regAddr      (regAddr),
  .regWrEn      (regWrEn),
  .regRdData    (regRdData),
  .txSentEvt    (txSentEvt),
  .txUnderrunEvt(txUnderrunEvt),
  .rxOverflowEvt(rxOverflowEvt),
  .irqOut       (irqOut)
);

// File: tb/test_dma_status_irq.sv
`timescale 1ns/1ps
module test_dma_status_irq;

  localparam logic [6:0] A_TX   = 7'h62;
  localparam logic [6:0] A_RX   = 7'h65;
  localparam logic [6:0] A_MASK = 7'h66;
  localparam logic [6:0] A_INTR = 7'h67;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        txSentEvt = 1'b0, txUnderrunEvt = 1'b0, rxRecvEvt = 1'b0, rxOverflowEvt = 1'b0;
  logic        irqOut;

  always #2.5 clk = ~clk;

  dma_status_irq i_dma_status_irq (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .txSentEvt(txSentEvt), .txUnderrunEvt(txUnderrunEvt),
    .rxRecvEvt(rxRecvEvt), .rxOverflowEvt(rxOverflowEvt), .irqOut(irqOut)
  );

  // reference state, updated from the requirements
  int unsigned mTxCnt, mRxCnt;
  logic mTxPkt, mTxUnd, mRxPkt, mRxOvf;
  logic [31:0] mMask;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] expDataQ[$];
  logic        expIrqQ[$];
  string       tagQ[$];

  function automatic logic [7:0] pendModel();
    return {1'b0, mRxOvf, 1'b0, mRxPkt, 2'b00, mTxUnd, mTxPkt};
  endfunction

  function automatic logic [31:0] readModel(logic [6:0] a);
    case (a)
      A_TX:   return {8'h0, 8'(mTxCnt), 14'h0, mTxUnd, mTxPkt};
      A_RX:   return {8'h0, 8'(mRxCnt), 13'h0, mRxOvf, 1'b0, mRxPkt};
      A_MASK: return mMask;
      A_INTR: return {24'h0, mMask[7:0] & pendModel()};
      default: return 32'h0;
    endcase
  endfunction

  task automatic pktModel(input bit inc, input bit dec, ref int unsigned c, ref logic f);
    if (inc && !dec) begin
      if (c != 255) c++;
      f = 1'b1;
    end else if (dec && !inc) begin
      if (c != 0) c--;
      if (c == 0) f = 1'b0;
    end else if (inc && dec) begin
      f = 1'b1;
    end
  endtask

  task automatic clearModel();
    mTxCnt = 0; mRxCnt = 0;
    mTxPkt = 0; mTxUnd = 0; mRxPkt = 0; mRxOvf = 0;
    mMask = '0;
  endtask

  // one clock of stimulus: optional write plus event pulses
  task automatic cyc(input bit wr, input logic [6:0] a, input logic [31:0] d,
                     input bit sent, input bit und, input bit rcv, input bit ovf);
    bit txAck, txUAck, rxAck, rxOAck;
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d;
    txSentEvt = sent; txUnderrunEvt = und; rxRecvEvt = rcv; rxOverflowEvt = ovf;
    txAck  = wr && a == A_TX && d[0];
    txUAck = wr && a == A_TX && d[1];
    rxAck  = wr && a == A_RX && d[0];
    rxOAck = wr && a == A_RX && d[2];
    pktModel(sent, txAck, mTxCnt, mTxPkt);
    pktModel(rcv, rxAck, mRxCnt, mRxPkt);
    if (und) mTxUnd = 1'b1; else if (txUAck) mTxUnd = 1'b0;
    if (ovf) mRxOvf = 1'b1; else if (rxOAck) mRxOvf = 1'b0;
    if (wr && a == A_MASK) mMask = d;
    @(posedge clk);
    #1;
    regWrEn = 0; regWrData = '0;
    txSentEvt = 0; txUnderrunEvt = 0; rxRecvEvt = 0; rxOverflowEvt = 0;
  endtask

  // driver: present the address and queue what should come back
  task automatic expectReg(input logic [6:0] a, input string tag);
    @(negedge clk);
    regAddr = a;
    expDataQ.push_back(readModel(a));
    expIrqQ.push_back((mMask[7:0] & pendModel()) != 0);
    tagQ.push_back(tag);
    @(posedge clk);
  endtask

  // monitor: compare design results against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expDataQ.size() > 0) begin
        logic [31:0] ed;
        logic        ei;
        string       t;
        ed = expDataQ.pop_front();
        ei = expIrqQ.pop_front();
        t  = tagQ.pop_front();
        checks++;
        if (regRdData !== ed || irqOut !== ei) begin
          errors++;
          $display("FAIL %s addr=%h data=%h irq=%b expected data=%h irq=%b",
                   t, regAddr, regRdData, irqOut, ed, ei);
        end
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    clearModel();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clearModel();
    rstN = 0;
    // R10: outputs quiet while reset is held
    @(negedge clk); #1;
    checks++;
    if (irqOut !== 1'b0) begin
      errors++;
      $display("FAIL R10 irq during reset=%b expected 0", irqOut);
    end
    repeat (2) @(negedge clk);
    rstN = 1;

    expectReg(A_TX, "R10");
    expectReg(A_RX, "R10");
    expectReg(A_MASK, "R10");
    expectReg(A_INTR, "R10");

    // R3 / R1: three sent packets
    repeat (3) cyc(0, A_TX, 0, 1, 0, 0, 0);
    expectReg(A_TX, "R3");
    // R8 / R9: masked off, then opened on the sent bit
    expectReg(A_INTR, "R8");
    cyc(1, A_MASK, 32'h0000_0001, 0, 0, 0, 0);
    expectReg(A_INTR, "R9");
    expectReg(A_MASK, "R8");

    // R5: acknowledge drains one at a time; zero write is ignored
    cyc(1, A_TX, 32'h1, 0, 0, 0, 0);
    expectReg(A_TX, "R5");
    cyc(1, A_TX, 32'h0, 0, 0, 0, 0);
    expectReg(A_TX, "R5");
    cyc(1, A_TX, 32'h1, 0, 0, 0, 0);
    expectReg(A_TX, "R5");
    cyc(1, A_TX, 32'h1, 0, 0, 0, 0);
    expectReg(A_TX, "R5");
    expectReg(A_INTR, "R9");
    cyc(1, A_TX, 32'h1, 0, 0, 0, 0);
    expectReg(A_TX, "R5");

    // R6: underrun set, raises irq through mask bit 1, cleared by a 1, wins a tie
    cyc(0, A_TX, 0, 0, 1, 0, 0);
    cyc(1, A_MASK, 32'hA5A5_0002, 0, 0, 0, 0);
    expectReg(A_TX, "R6");
    expectReg(A_INTR, "R6");
    cyc(1, A_TX, 32'h2, 0, 0, 0, 0);
    expectReg(A_TX, "R6");
    cyc(1, A_TX, 32'h2, 0, 1, 0, 0);
    expectReg(A_TX, "R6");
    expectReg(A_MASK, "R8");

    // R2: receive side, overflow and packets
    cyc(0, A_RX, 0, 0, 0, 1, 0);
    cyc(0, A_RX, 0, 0, 0, 1, 1);
    expectReg(A_RX, "R2");
    cyc(1, A_MASK, 32'h0000_00F0, 0, 0, 0, 0);
    expectReg(A_INTR, "R8");
    cyc(1, A_RX, 32'h4, 0, 0, 0, 0);
    expectReg(A_RX, "R6");
    expectReg(A_INTR, "R8");

    // R7: event and acknowledge together
    cyc(1, A_RX, 32'h1, 0, 0, 1, 0);
    expectReg(A_RX, "R7");
    cyc(1, A_TX, 32'h3, 1, 0, 0, 0);
    expectReg(A_TX, "R7");

    // R8: interrupt word is read-only
    cyc(1, A_INTR, 32'hFFFF_FFFF, 0, 0, 0, 0);
    expectReg(A_INTR, "R8");
    expectReg(A_MASK, "R8");

    // R4: saturation and recovery
    repeat (260) cyc(0, A_TX, 0, 1, 0, 0, 0);
    expectReg(A_TX, "R4");
    cyc(1, A_TX, 32'h1, 0, 0, 0, 0);
    expectReg(A_TX, "R4");
    cyc(1, A_MASK, 32'hFF, 0, 0, 0, 0);
    expectReg(A_INTR, "R9");

    // R10: reset mid-run clears everything
    doReset();
    rstN = 1;
    expectReg(A_TX, "R10");
    expectReg(A_RX, "R10");
    expectReg(A_MASK, "R10");
    expectReg(A_INTR, "R10");

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule